// File: doc/BRIEF.md
# Column-Mixing Stage with Masked Doubling

This block performs the column-mixing step of an AES round on an entire 128-bit state. All four columns pass through the datapath in parallel. The result is held in a single output register stage. Each state byte is doubled in GF(2^8) in a mask-then-shift form. A mask is built from the byte's top bit and XORed onto the byte. The sum is shifted left by one place, and the top bit fills the vacated least significant bit. A network of XORs that spans the whole state then combines the doubled and original bytes.

The state enters and leaves through valid/ready streams. An input beat is taken on any rising edge where `in_valid` and `in_ready` are both high. The mixed state appears on the output one cycle later. The output register holds one beat. While that beat waits with `out_ready` low, `in_ready` stays low, so back-pressure propagates in the same cycle. When the downstream side takes the held beat, a new input beat may enter on the same edge, so a stream that is never stalled moves one state per cycle. There is no combinational path from `in_valid` to `out_valid`.

Top module: `mix_columns_stage`

## Requirements
- R1: Each byte x is doubled as ((x XOR m) << 1) with bit 0 set to x[7], where m has x[7] in bits 3, 2 and 0 and zeros elsewhere. The result equals the GF(2^8) doubling modulo 0x11B.
- R2: For a column (a0,a1,a2,a3), output byte i is 2·a_i ⊕ 3·a_(i+1) ⊕ a_(i+2) ⊕ a_(i+3), with indices taken mod 4. Example: db 13 53 45 becomes 8e 4d a1 bc.
- R3: State byte k occupies bits [127-8k -: 8], so byte 0 is the most significant. Column c holds bytes 4c to 4c+3, with byte 4c being a0.
- R4: The four columns are transformed on the same cycle, and each column's result depends only on its own four bytes.
- R5: An input beat accepted on edge n shows up on `out_data`, with `out_valid` high, right after edge n+1's preceding edge. In other words, `out_valid` rises on the edge that accepts the beat.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R7: After reset, `out_valid` is low.
- R8: `in_ready` is high exactly when the output register is empty or `out_ready` is high.
- R9: `in_data` has no effect when `in_valid` is low. In that case no output beat is produced, and a beat that is being held is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input state beat is present |
| in_ready | output | 1 | Stage can take an input beat |
| in_data | input | 128 | Input state, byte 0 in bits 127:120 |
| out_valid | output | 1 | Mixed state beat is present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 128 | Mixed state, same byte order |

## Verification
Stimulus includes bytes whose top bit is set and bytes whose top bit is clear. A mask placed in the wrong bits, or a top bit left out of the LSB, would corrupt the doubled values, and the known column vectors would not match. Distinct states are placed in each column to expose a byte-order swap or a column that reads its neighbour's bytes. The bench lowers `out_ready` for several cycles while beats are pending. A stage that dropped or overwrote a held beat would lose an entry from the scoreboard or return stale data. It also applies garbage `in_data` with `in_valid` low, so a stage that captured it would emit an unexpected beat.

// File: rtl/mix_columns_pkg.sv
package mix_columns_pkg;
  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 4;
  localparam int COL_W     = BYTE_W * COL_BYTES;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [COL_W-1:0]  col_t;

  // bits of the reduction mask (set to the top bit), before the shift
  localparam logic [BYTE_W-1:0] FOLD_SEL = 8'b0000_1101;
endpackage

// File: rtl/mc_xtime.sv
module mc_xtime
  import mix_columns_pkg::*;
(
  input  byte_t x_i,
  output byte_t dbl_o
);
  byte_t mask;
  byte_t folded;
  always_comb begin
    mask   = FOLD_SEL & {BYTE_W{x_i[BYTE_W-1]}};
    folded = x_i ^ mask;
    dbl_o  = {folded[BYTE_W-2:0], x_i[BYTE_W-1]};
  end
endmodule

// File: rtl/mc_column.sv
module mc_column
  import mix_columns_pkg::*;
(
  input  col_t col_i,
  output col_t col_o
);
  byte_t a   [COL_BYTES];
  byte_t d   [COL_BYTES];
  byte_t r   [COL_BYTES];

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_byte
    assign a[i] = col_i[COL_W-1-BYTE_W*i -: BYTE_W];
    mc_xtime u_xt (.x_i(a[i]), .dbl_o(d[i]));
  end

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_mix
    localparam int J1 = (i + 1) % COL_BYTES;
    localparam int J2 = (i + 2) % COL_BYTES;
    localparam int J3 = (i + 3) % COL_BYTES;
    assign r[i] = d[i] ^ d[J1] ^ a[J1] ^ a[J2] ^ a[J3];
    assign col_o[COL_W-1-BYTE_W*i -: BYTE_W] = r[i];
  end
endmodule

// File: rtl/mc_out_reg.sv
module mc_out_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic take;
  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) m_data <= s_data;
  end
endmodule

// File: rtl/mix_columns_stage.sv
module mix_columns_stage
  import mix_columns_pkg::*;
#(
  parameter int N_COLS  = 4,
  localparam int STATE_W = N_COLS * COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [STATE_W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [STATE_W-1:0] out_data
);
  logic [STATE_W-1:0] mixed;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    mc_column u_col (
      .col_i(in_data[STATE_W-1-COL_W*c -: COL_W]),
      .col_o(mixed  [STATE_W-1-COL_W*c -: COL_W])
    );
  end

  mc_out_reg #(.W(STATE_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (mixed),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (out_data)
  );
endmodule

// File: rtl/mix_columns_chk.sv
module mix_columns_chk #(
  parameter int STATE_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [STATE_W-1:0] out_data
);
  // R5
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R9
  no_phantom_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (!out_valid || out_ready) |=> !out_valid);
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind mix_columns_stage mix_columns_chk #(.STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/mix_columns_stage_test.sv
module mix_columns_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  logic [SW-1:0] expq[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mix_columns_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [7:0] dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [SW-1:0] model(input logic [SW-1:0] s);
    logic [SW-1:0] r;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a [4];
      for (int i = 0; i < 4; i++) a[i] = s[SW-1-8*(4*c+i) -: 8];
      for (int i = 0; i < 4; i++)
        r[SW-1-8*(4*c+i) -: 8] = dbl(a[i]) ^ dbl(a[(i+1)%4]) ^ a[(i+1)%4]
                                ^ a[(i+2)%4] ^ a[(i+3)%4];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [SW-1:0] d);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    expq.push_back(model(d));
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_data  = {4{32'hdead_beef}};
  endtask

  // scoreboard monitor
  logic [SW-1:0] held;
  bit            stalled = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        // R6: beat held while the sink is not ready
        check(out_valid && out_data == held, "R6", out_data, held);
      end
      stalled = out_valid && !out_ready;
      held    = out_data;
      // R8
      check(in_ready == (!out_valid || out_ready), "R8",
            {127'd0, in_ready}, {127'd0, !out_valid || out_ready});
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9 unexpected beat", out_data, '0);
        end else begin
          logic [SW-1:0] e;
          e = expq.pop_front();
          check(out_data == e, "R1 R2 R3 R4", out_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog", '0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7
    check(out_valid == 1'b0, "R7", {127'd0, out_valid}, '0);
    rst_n = 1'b1;
    // R2: known column vectors, one per column, distinct (R3, R4)
    send({32'hdb135345, 32'hf20a225c, 32'h01010101, 32'hc6c6c6c6});
    @(negedge clk);
    check(out_data == {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hc6c6c6c6},
          "R2", out_data,
          {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hc6c6c6c6});
    // R1: all top bits set / clear
    send({32'hd4d4d4d5, 32'h2d26314c, 32'h80808080, 32'hffffffff});
    send({16{8'h7f}});
    send({32'h01020304, 32'h80000000, 32'h00000000, 32'h00000080});
    // R5: latency, out_valid one edge after acceptance
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = {4{32'h455313db}};
    @(negedge clk);
    expq.push_back(model(in_data));
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R5", {127'd0, out_valid}, {127'd0, 1'b1});
    // R9: garbage with in_valid low
    repeat (5) begin
      @(posedge clk); #1;
      in_data = {4{32'h12345678}} ^ {SW{out_valid}};
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R9", {127'd0, out_valid}, '0);
    // R6/R8: stall the sink while sending
    fork
      begin
        @(posedge clk); #1; out_ready = 1'b0;
        repeat (6) @(posedge clk);
        #1; out_ready = 1'b1;
        @(posedge clk); #1; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1; out_ready = 1'b1;
      end
      begin
        for (int k = 0; k < 6; k++)
          send({4{32'h9e3779b9 * (k + 1)}} ^ {SW{k[0]}});
      end
    join
    // back-to-back stream
    @(posedge clk); #1;
    in_valid = 1'b1;
    for (int k = 0; k < 8; k++) begin
      in_data = {4{32'h3c6ef372 + 32'(k * 77)}};
      @(negedge clk);
      expq.push_back(model(in_data));
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R9 queue drained", SW'(expq.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule